// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block supplies the word address for a four-beat burst access to a memory array. When a burst starts, it captures an external address. Each later advance produces the next address in the burst. Only the two least significant address bits change during a burst, so all four beats stay inside one aligned group of four words. The upper bits are passed through from the captured address without change.

A static order input selects how the two low bits move. In interleaved order, the low bits are the captured low bits XORed with a two-bit beat count. In linear order, the low bits are the captured low bits plus the beat count, wrapping from 3 back to 0.

A burst can be started by either of two start strobes, one from a processor side and one from a cache-controller side. An active-low step input either advances the burst by one beat or holds the current address for wait states.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, the captured address and the beat count are held at zero, so `cur_addr` reads 0 on the first sampling after reset.
- R2: When `start_cpu` or `start_ctl` is high at a rising edge, `ld_addr` is captured and the beat count restarts at 0. `cur_addr` equals `ld_addr` after that edge.
- R3: The two start strobes behave identically. A start takes priority over a step at the same edge, so the beat count is 0 after that edge even if `step_n` is low.
- R4: With no start and `step_n` low at a rising edge, the beat count advances by one, modulo 4.
- R5: With no start and `step_n` high at a rising edge, `cur_addr` does not change (wait state).
- R6: With `order_il` = 1 (interleaved), `cur_addr[1:0]` equals the captured low bits XOR the beat count. For example, start 01 gives 01, 00, 11, 10, and start 10 gives 10, 11, 00, 01.
- R7: With `order_il` = 0 (linear), `cur_addr[1:0]` equals the captured low bits plus the beat count, modulo 4. For example, start 10 gives 10, 11, 00, 01.
- R8: Steps after the fourth beat continue the same modulo-4 sequence. The fifth beat returns to the starting low bits.
- R9: Between starts, `cur_addr[ADDR_W-1:2]` never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_cpu | input | 1 | Processor-side burst start strobe |
| start_ctl | input | 1 | Controller-side burst start strobe |
| ld_addr | input | ADDR_W | External address captured on a start |
| step_n | input | 1 | Active-low advance; high holds the burst |
| order_il | input | 1 | 1 = interleaved order, 0 = linear order; held static |
| cur_addr | output | ADDR_W | Current burst word address |

## Verification
Every result is due one rising edge after the stimulus that causes it. A start, a step or a hold presented before an edge shows up on `cur_addr` right after that edge, because the output is formed combinationally from the two state registers.

The bench drives inputs on the falling edge, waits for one rising edge, and samples on the following falling edge, so each check lands exactly one edge after its stimulus. Expected low bits come from a beat counter kept in the bench and the XOR or modulo-4 sum of the requirements. The sweep covers both orders, all four starting offsets, both strobes, holds between steps, and runs past the fourth beat.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cpu,
  input  logic              start_ctl,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              step_n,
  input  logic              order_il,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat_q;
  logic              start;
  logic [CNT_W-1:0]  low;

  assign start = start_cpu | start_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (start) begin
      base_q <= ld_addr;
      beat_q <= '0;
    end else if (!step_n) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign low      = order_il ? (base_q[CNT_W-1:0] ^ beat_q) : (base_q[CNT_W-1:0] + beat_q);
  assign cur_addr = {base_q[ADDR_W-1:CNT_W], low};

  // R1
  reset_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> cur_addr == '0);

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cur_addr == $past(ld_addr));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && step_n) |=> $stable(cur_addr));

  // R9
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W]));

  // R7
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step_n && !order_il && $stable(order_il))
      |=> cur_addr[CNT_W-1:0] == CNT_W'($past(cur_addr[CNT_W-1:0]) + 1'b1));

  // R6
  il_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step_n && order_il && $stable(order_il))
      |=> $countones(cur_addr[CNT_W-1:0] ^ $past(cur_addr[CNT_W-1:0])) >= 1);
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_cpu, start_ctl, step_n, order_il;
  logic [AW-1:0] ld_addr;
  logic [AW-1:0] cur_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_cpu(start_cpu), .start_ctl(start_ctl),
    .ld_addr(ld_addr), .step_n(step_n), .order_il(order_il), .cur_addr(cur_addr)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (cur_addr !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, cur_addr, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] b, input int beat, input logic il);
    logic [1:0] s, k, l;
    s = b[1:0];
    k = 2'(beat % 4);
    l = il ? (s ^ k) : 2'((s + k) % 4);
    return {b[AW-1:2], l};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_cpu = 0; start_ctl = 0; step_n = 1; order_il = 1;
    ld_addr = 15'h5A5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset", '0);

    for (int m = 0; m < 2; m++) begin
      rst_n = 0; order_il = m[0];
      repeat (2) tick();
      rst_n = 1;
      tick();
      check("R1 reset", '0);
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] b;
        int beat;
        b = AW'((s * 15'h0935 + m * 15'h1234) << 2) | AW'(s);
        ld_addr = b;
        if (s % 2 == 0) start_cpu = 1; else start_ctl = 1;
        step_n = (s == 3) ? 1'b0 : 1'b1;
        tick();
        start_cpu = 0; start_ctl = 0;
        ld_addr = ~b;
        beat = 0;
        check(s == 3 ? "R3 start over step" : "R2 load", b);
        for (int k = 0; k < 9; k++) begin
          if (k % 3 == 2) begin
            step_n = 1;
            tick();
            check("R5 hold", expect_addr(b, beat, order_il));
          end
          step_n = 0;
          tick();
          beat++;
          if (beat >= 4)
            check("R8 wrap continue", expect_addr(b, beat, order_il));
          else if (order_il)
            check("R6 interleaved", expect_addr(b, beat, order_il));
          else
            check("R7 linear", expect_addr(b, beat, order_il));
          if (cur_addr[AW-1:2] !== b[AW-1:2]) begin
            errors++;
            $display("FAIL R9 upper actual=%h expected=%h", cur_addr[AW-1:2], b[AW-1:2]);
          end
          checks++;
        end
        step_n = 1;
      end
      ld_addr = 15'h0002;
      start_ctl = 1; step_n = 0;
      tick();
      start_ctl = 0;
      check("R3 ctl strobe with step", 15'h0002);
      tick();
      check("R4 step", expect_addr(15'h0002, 1, order_il));
      step_n = 1;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule